// File: doc/BRIEF.md
# DDR Byte-Wide Burst Memory Responder

This block is the memory-device end of a double-data-rate, eight-bit, chip-select framed memory bus. A bus master lowers chip select while the bus clock is low. It then sends a 48-bit command-address, one byte on every clock edge. The responder decodes the direction, the target space, the burst style and the word address from those six bytes.

While the command-address arrives, the responder drives the strobe line to report whether a refresh collision doubles the initial latency. A periodic model decides this, with one transaction in every `REFRESH_PERIOD`. After the latency edges the responder serves the burst. On a read it drives data with a strobe that it generates itself. On a write it treats the strobe line as a per-byte mask. Bursts step linearly through the word array or wrap inside an aligned group of `WRAP_WORDS` words.

A second, register address space holds a fixed identification word and a writable configuration word. The whole block runs on one fast system clock and oversamples the bus clock, chip select, data and strobe. This makes it a fully synchronous partner for checking a master controller. Raising chip select ends any burst at once.

Top module: `hb_dev_responder`

## Requirements
- R1: A transaction starts only when chip select falls while the bus clock is low; the next six bus-clock edges (both directions) carry command-address bytes, most significant byte (bits 47..40) first. If chip select falls while the clock is high, no transaction starts and the block drives nothing until chip select rises again.
- R2: Command-address bit 47 selects read (1) or write (0), bit 46 selects register space (1) or memory space (0), and bit 45 selects wrapped (0) or linear (1) bursts.
- R3: The word address is command-address bits 34..16 followed by bits 2..0 as the three lowest address bits; the low `ADDR_W` bits of it index the array, and bits 44..35 and 15..3 have no effect.
- R4: Throughout the command-address phase `rwds_oe` is 1 and `rwds_out` is 1 exactly for transactions whose index k since reset (counting from 0, started transactions only) satisfies k mod `REFRESH_PERIOD` = `REFRESH_PERIOD`-1, and 0 otherwise.
- R5: After the sixth command-address edge, the block lets 2*`LATENCY` bus-clock edges pass, or 4*`LATENCY` when R4 signalled a collision, before the first data edge; `dq_oe` stays 0 throughout this latency.
- R6: On a read, each data edge drives one byte: the high byte of the current word on a rising edge and the low byte on a falling edge. Along with each byte, `dq_oe` is 1 and `rwds_out` is 1 for the high byte and 0 for the low byte.
- R7: On a write, the byte on a rising edge goes to bits 15..8 of the current word and the byte on a falling edge to bits 7..0; a byte is stored only if `rwds_in` is 0 on its edge.
- R8: The word address advances after each falling data edge: linear bursts add one modulo 2^`ADDR_W`, wrapped bursts add one within the aligned group of `WRAP_WORDS` words.
- R9: When chip select is high the block ends any burst, turns off `dq_oe` and `rwds_oe` from the next clock on, and ignores bus-clock edges; bytes completed earlier stay stored.
- R10: In register space, word 0 reads the `ID_WORD` parameter and ignores writes, word 1 is a configuration word that resets to `CFG_RESET` and takes masked writes, and every other word reads 0.
- R11: After reset `dq_oe` and `rwds_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ck | input | 1 | Bus clock from the master |
| bus_csn | input | 1 | Chip select, active low |
| dq_in | input | 8 | Data bus as driven by the master |
| rwds_in | input | 1 | Strobe line as driven by the master (write mask) |
| dq_out | output | 8 | Read data driven by the responder |
| dq_oe | output | 1 | Enable for `dq_out` |
| rwds_out | output | 1 | Latency flag or read strobe driven by the responder |
| rwds_oe | output | 1 | Enable for `rwds_out` |

## Verification
The assertions assume that the master holds data, the mask and chip select steady at each system-clock sample in which a bus-clock edge is seen. They also assume that bus-clock edges are at least two system clocks apart and that chip select rises only with the bus clock low after a whole word. The bench keeps to this by changing every bus input on the falling system-clock edge. Each bus-clock phase lasts four system clocks, and data is placed one system clock before the clock toggles. Every burst is closed on a word boundary, and the edges that follow an abort are sent only after chip select is already high.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_LAT  = 2'd2,
        ST_DATA = 2'd3
    } hbd_state_e;

    typedef struct packed {
        logic        rd;
        logic        reg_space;
        logic        linear;
        logic [21:0] waddr;
    } hbd_cmd_t;

    localparam int CMD_BYTES = 6;

    function automatic hbd_cmd_t hbd_decode(input logic [47:0] ca);
        hbd_cmd_t c;
        c.rd        = ca[47];
        c.reg_space = ca[46];
        c.linear    = ca[45];
        c.waddr     = {ca[34:16], ca[2:0]};
        return c;
    endfunction

    function automatic logic [21:0] hbd_next_addr(input logic [21:0] a,
                                                  input logic        linear,
                                                  input logic [21:0] grp_mask);
        logic [21:0] inc;
        inc = a + 22'd1;
        return linear ? inc : ((a & ~grp_mask) | (inc & grp_mask));
    endfunction

endpackage

// File: rtl/hbd_edge_sense.sv
module hbd_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic bus_ck,
    input  logic bus_csn,
    output logic start,
    output logic stop,
    output logic edge_evt,
    output logic edge_rise
);
    logic ck_q;
    logic csn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_q  <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            ck_q  <= bus_ck;
            csn_q <= bus_csn;
        end
    end

    assign start     = csn_q && !bus_csn && !bus_ck;
    assign stop      = bus_csn;
    assign edge_evt  = (bus_ck != ck_q) && !bus_csn;
    assign edge_rise = bus_ck;

endmodule

// File: rtl/hbd_refresh_model.sv
module hbd_refresh_model #(
    parameter int PERIOD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic extra_now
);
    localparam int CW = $clog2(PERIOD + 1);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] phase_q;

    assign extra_now = (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (start) begin
            phase_q <= extra_now ? '0 : phase_q + CW'(1);
        end
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= LAST); // R4

endmodule

// File: rtl/hbd_store.sv
module hbd_store #(
    parameter int          ADDR_W    = 6,
    parameter logic [15:0] ID_WORD   = 16'hA5C3,
    parameter logic [15:0] CFG_RESET = 16'h8F1F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        lane_we,
    input  logic              reg_space,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wbyte,
    output logic [15:0]       rdata
);
    localparam int WORDS = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] REG_ID  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] REG_CFG = ADDR_W'(1);

    logic [1:0][7:0] lane_rd;
    logic [15:0]     cfg_q;

    for (genvar L = 0; L < 2; L++) begin : g_lane
        logic [7:0] lane_mem [WORDS];

        always_ff @(posedge clk) begin
            if (lane_we[L] && !reg_space) begin
                lane_mem[addr] <= wbyte;
            end
        end

        assign lane_rd[L] = lane_mem[addr];

        AST_LANE_STORED: assert property (@(posedge clk) disable iff (rst)
            $past(lane_we[L] && !reg_space) |-> lane_mem[$past(addr)] == $past(wbyte)); // R7
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (reg_space && addr == REG_CFG) begin
            if (lane_we[1]) cfg_q[15:8] <= wbyte;
            if (lane_we[0]) cfg_q[7:0]  <= wbyte;
        end
    end

    always_comb begin
        if (!reg_space)           rdata = lane_rd;
        else if (addr == REG_ID)  rdata = ID_WORD;
        else if (addr == REG_CFG) rdata = cfg_q;
        else                      rdata = 16'h0000;
    end

endmodule

// File: rtl/hb_dev_responder.sv
module hb_dev_responder
    import hbd_pkg::*;
#(
    parameter int          ADDR_W         = 6,
    parameter int          WRAP_WORDS     = 16,
    parameter int          LATENCY        = 2,
    parameter int          REFRESH_PERIOD = 3,
    parameter logic [15:0] ID_WORD        = 16'hA5C3,
    parameter logic [15:0] CFG_RESET      = 16'h8F1F
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_ck,
    input  logic       bus_csn,
    input  logic [7:0] dq_in,
    input  logic       rwds_in,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    output logic       rwds_out,
    output logic       rwds_oe
);
    localparam int CW = $clog2(4 * LATENCY + CMD_BYTES + 2);
    localparam int WB = $clog2(WRAP_WORDS);
    localparam logic [CW-1:0]   LAST_CMD   = CW'(CMD_BYTES - 1);
    localparam logic [CW-1:0]   LAST_NORM  = CW'(2 * LATENCY - 1);
    localparam logic [CW-1:0]   LAST_EXTRA = CW'(4 * LATENCY - 1);
    localparam logic [21:0]     GRP_MASK   = 22'(WRAP_WORDS - 1);

    logic start, stop, edge_evt, edge_rise;
    logic extra_now;

    hbd_state_e        state_q;
    logic [CW-1:0]     cnt_q;
    logic              extra_q;
    logic [39:0]       ca_sr;
    logic              rd_q, reg_q, lin_q;
    logic [ADDR_W-1:0] addr_q;
    logic [15:0]       rdata;
    logic [1:0]        lane_we;
    logic [21:0]       addr_nx;
    hbd_cmd_t          cmd;

    hbd_edge_sense u_edge (
        .clk(clk), .rst(rst), .bus_ck(bus_ck), .bus_csn(bus_csn),
        .start(start), .stop(stop), .edge_evt(edge_evt), .edge_rise(edge_rise)
    );

    hbd_refresh_model #(.PERIOD(REFRESH_PERIOD)) u_refresh (
        .clk(clk), .rst(rst), .start(start && state_q == ST_IDLE),
        .extra_now(extra_now)
    );

    hbd_store #(.ADDR_W(ADDR_W), .ID_WORD(ID_WORD), .CFG_RESET(CFG_RESET)) u_store (
        .clk(clk), .rst(rst), .lane_we(lane_we), .reg_space(reg_q),
        .addr(addr_q), .wbyte(dq_in), .rdata(rdata)
    );

    assign cmd     = hbd_decode({ca_sr, dq_in});
    assign addr_nx = hbd_next_addr(22'(addr_q), lin_q, GRP_MASK);

    always_comb begin
        lane_we = 2'b00;
        if (state_q == ST_DATA && edge_evt && !rd_q && !rwds_in) begin
            lane_we = edge_rise ? 2'b10 : 2'b01;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            extra_q  <= 1'b0;
            ca_sr    <= '0;
            rd_q     <= 1'b0;
            reg_q    <= 1'b0;
            lin_q    <= 1'b0;
            addr_q   <= '0;
            dq_out   <= '0;
            dq_oe    <= 1'b0;
            rwds_out <= 1'b0;
            rwds_oe  <= 1'b0;
        end else if (stop) begin
            state_q  <= ST_IDLE;
            dq_oe    <= 1'b0;
            rwds_out <= 1'b0;
            rwds_oe  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q  <= ST_CMD;
                        cnt_q    <= '0;
                        extra_q  <= extra_now;
                        rwds_oe  <= 1'b1;
                        rwds_out <= extra_now;
                    end
                end
                ST_CMD: begin
                    if (edge_evt) begin
                        ca_sr <= {ca_sr[31:0], dq_in};
                        if (cnt_q == LAST_CMD) begin
                            state_q  <= ST_LAT;
                            cnt_q    <= '0;
                            rd_q     <= cmd.rd;
                            reg_q    <= cmd.reg_space;
                            lin_q    <= cmd.linear;
                            addr_q   <= cmd.waddr[ADDR_W-1:0];
                            rwds_out <= 1'b0;
                            rwds_oe  <= cmd.rd;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                ST_LAT: begin
                    if (edge_evt) begin
                        if (cnt_q == (extra_q ? LAST_EXTRA : LAST_NORM)) begin
                            state_q <= ST_DATA;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                end
                ST_DATA: begin
                    if (edge_evt) begin
                        if (rd_q) begin
                            dq_out   <= edge_rise ? rdata[15:8] : rdata[7:0];
                            dq_oe    <= 1'b1;
                            rwds_out <= edge_rise;
                        end
                        if (!edge_rise) begin
                            addr_q <= addr_nx[ADDR_W-1:0];
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_csn |=> (!dq_oe && !rwds_oe)); // R9

    AST_NO_WRITE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
        (lane_we != 2'b00) |-> !bus_csn); // R9

    AST_FIRST_BYTE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> rwds_out); // R6

    AST_DATA_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> rwds_oe); // R6

    AST_CMD_DRIVES_FLAG: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CMD) |-> rwds_oe); // R4

    AST_WRAP_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && $past(state_q == ST_DATA) && !lin_q)
            |-> addr_q[ADDR_W-1:WB] == $past(addr_q[ADDR_W-1:WB])); // R8

endmodule

// File: tb/hb_dev_responder_test.sv
module hb_dev_responder_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          HALF       = 4;
    localparam int          AW         = 6;
    localparam int          WORDS      = 64;
    localparam int          WRAPW      = 16;
    localparam int          LAT        = 2;
    localparam int          RP         = 3;
    localparam logic [15:0] ID_W       = 16'hA5C3;
    localparam logic [15:0] CFG_R      = 16'h8F1F;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_ck = 1'b0;
    logic       bus_csn = 1'b1;
    logic [7:0] dq_in = 8'h00;
    logic       rwds_in = 1'b0;
    logic [7:0] dq_out;
    logic       dq_oe, rwds_out, rwds_oe;

    hb_dev_responder #(
        .ADDR_W(AW), .WRAP_WORDS(WRAPW), .LATENCY(LAT), .REFRESH_PERIOD(RP),
        .ID_WORD(ID_W), .CFG_RESET(CFG_R)
    ) uut (
        .clk(clk), .rst(rst), .bus_ck(bus_ck), .bus_csn(bus_csn),
        .dq_in(dq_in), .rwds_in(rwds_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .rwds_out(rwds_out), .rwds_oe(rwds_oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int          checks = 0;
    int          errors = 0;
    int          txn_k  = 0;
    bit          done   = 0;
    logic [15:0] model [WORDS];
    logic [15:0] cfg_m;
    logic [15:0] wdat [128];
    logic [1:0]  wmsk [128];
    logic [15:0] rdat [128];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int nxt(input int a, input bit lin);
        if (lin) return (a + 1) % WORDS;
        return (a / WRAPW) * WRAPW + ((a + 1) % WRAPW);
    endfunction

    function automatic logic [15:0] expw(input bit asr, input int a);
        if (!asr) return model[a];
        if (a == 0) return ID_W;
        if (a == 1) return cfg_m;
        return 16'h0000;
    endfunction

    // one framed transaction; nwords whole words of data, then chip select rises
    task automatic run(input bit rd, input bit asr, input bit lin, input logic [21:0] wa,
                       input int nwords, input logic [12:0] junk);
        logic [47:0] ca;
        bit          extra;
        int          w;
        extra = ((txn_k % RP) == RP - 1);
        txn_k++;
        ca = {rd, asr, lin, junk[9:0], wa[21:3], junk, wa[2:0]};
        step(1);
        bus_csn = 1'b0;
        step(HALF);
        for (int e = 0; e < 6; e++) begin
            dq_in = ca[47 - 8 * e -: 8];
            step(1);
            bus_ck = ~bus_ck;
            step(HALF - 1);
            if (e == 2) chk(rwds_oe === 1'b1 && rwds_out === extra, "R4 latency flag",
                            {rwds_oe, rwds_out}, {1'b1, extra});
        end
        w = extra ? 4 * LAT : 2 * LAT;
        for (int e = 0; e < w; e++) begin
            bus_ck = ~bus_ck;
            step(HALF);
            if (rd && e == w - 1) chk(dq_oe === 1'b0, "R5 quiet in latency", dq_oe, 0);
        end
        for (int b = 0; b < 2 * nwords; b++) begin
            if (rd) begin
                bus_ck = ~bus_ck;
                step(HALF);
                if (b % 2 == 0) rdat[b / 2][15:8] = dq_out;
                else            rdat[b / 2][7:0]  = dq_out;
                if (b == 0) chk(dq_oe === 1'b1, "R5 data after latency", dq_oe, 1);
                chk(rwds_out === ((b % 2) == 0) && dq_oe === 1'b1, "R6 strobe",
                    {dq_oe, rwds_out}, {1'b1, ((b % 2) == 0)});
            end else begin
                dq_in   = (b % 2 == 0) ? wdat[b / 2][15:8] : wdat[b / 2][7:0];
                rwds_in = (b % 2 == 0) ? wmsk[b / 2][1] : wmsk[b / 2][0];
                step(1);
                bus_ck = ~bus_ck;
                step(HALF - 1);
            end
        end
        rwds_in = 1'b0;
        step(1);
        bus_csn = 1'b1;
        step(3);
        chk(dq_oe === 1'b0 && rwds_oe === 1'b0, "R9 release after cs high",
            {dq_oe, rwds_oe}, 0);
    endtask

    task automatic model_write(input bit asr, input bit lin, input int start, input int n);
        int a = start;
        for (int i = 0; i < n; i++) begin
            if (!asr) begin
                if (!wmsk[i][1]) model[a][15:8] = wdat[i][15:8];
                if (!wmsk[i][0]) model[a][7:0]  = wdat[i][7:0];
            end else if (a == 1) begin
                if (!wmsk[i][1]) cfg_m[15:8] = wdat[i][15:8];
                if (!wmsk[i][0]) cfg_m[7:0]  = wdat[i][7:0];
            end
            a = nxt(a, lin);
        end
    endtask

    task automatic check_read(input bit asr, input bit lin, input int start, input int n,
                              input string req);
        int a = start;
        for (int i = 0; i < n; i++) begin
            chk(rdat[i] === expw(asr, a), req, rdat[i], expw(asr, a));
            a = nxt(a, lin);
        end
    endtask

    task automatic clear_masks;
        for (int i = 0; i < 128; i++) wmsk[i] = 2'b00;
    endtask

    initial begin
        cfg_m = CFG_R;
        clear_masks();
        step(4);
        rst = 1'b0;
        step(2);
        chk(dq_oe === 1'b0 && rwds_oe === 1'b0, "R11 reset state", {dq_oe, rwds_oe}, 0);

        // R8 linear write filling the whole array, R2 write decode
        for (int i = 0; i < WORDS; i++) wdat[i] = 16'(i * 16'h0901) ^ 16'h5A3C;
        run(0, 0, 1, 22'd0, WORDS, 13'd0);
        model_write(0, 1, 0, WORDS);
        run(1, 0, 1, 22'd0, WORDS, 13'd0);
        check_read(0, 1, 0, WORDS, "R6 R2 linear read");

        // R8 linear burst crossing the top of the array (collision latency)
        run(1, 0, 1, 22'd60, 8, 13'd0);
        check_read(0, 1, 60, 8, "R8 linear modulo");

        // R7 masked writes, every mask combination
        for (int i = 0; i < 4; i++) begin
            wdat[i] = 16'hC0DE + 16'(i * 16'h1111);
            wmsk[i] = 2'(i);
        end
        run(0, 0, 1, 22'd10, 4, 13'd0);
        model_write(0, 1, 10, 4);
        clear_masks();
        run(1, 0, 1, 22'd10, 4, 13'd0);
        check_read(0, 1, 10, 4, "R7 byte mask");

        // R8 wrapped read and wrapped write
        run(1, 0, 0, 22'd13, 20, 13'd0);
        check_read(0, 0, 13, 20, "R8 wrapped read");
        for (int i = 0; i < 5; i++) wdat[i] = 16'h7E00 + 16'(i);
        run(0, 0, 0, 22'd30, 5, 13'd0);
        model_write(0, 0, 30, 5);
        run(1, 0, 1, 22'd16, 16, 13'd0);
        check_read(0, 1, 16, 16, "R8 wrapped write");

        // R3 address assembly, reserved and high bits ignored
        wdat[0] = 16'hBEEF;
        run(0, 0, 1, 22'h3ABC00 | 22'h2D, 1, 13'h1ACE);
        model_write(0, 1, 'h2D, 1);
        run(1, 0, 1, 22'h00002D, 1, 13'd0);
        check_read(0, 1, 'h2D, 1, "R3 address decode");
        run(1, 0, 1, 22'h000028, 8, 13'h0F0F);
        check_read(0, 1, 'h28, 8, "R3 neighbours");

        // R9 abort: write only two words, then edges with chip select high
        for (int i = 0; i < 6; i++) wdat[i] = 16'h1200 + 16'(i);
        run(0, 0, 1, 22'd40, 2, 13'd0);
        model_write(0, 1, 40, 2);
        dq_in = 8'hEE;
        rwds_in = 1'b0;
        for (int e = 0; e < 4; e++) begin
            step(1);
            bus_ck = ~bus_ck;
            step(HALF - 1);
        end
        chk(dq_oe === 1'b0 && rwds_oe === 1'b0, "R9 idle edges", {dq_oe, rwds_oe}, 0);
        run(1, 0, 1, 22'd40, 6, 13'd0);
        check_read(0, 1, 40, 6, "R9 abort keeps memory");
        run(1, 0, 1, 22'd0, 3, 13'd0);
        check_read(0, 1, 0, 3, "R9 short read");

        // R10 register space
        run(1, 1, 1, 22'd0, 3, 13'd0);
        check_read(1, 1, 0, 3, "R10 R2 register read");
        wdat[0] = 16'h1234;
        wdat[1] = 16'h00F0;
        wmsk[1] = 2'b10;
        run(0, 1, 1, 22'd0, 2, 13'd0);
        model_write(1, 1, 0, 2);
        clear_masks();
        run(1, 1, 1, 22'd0, 3, 13'd0);
        check_read(1, 1, 0, 3, "R10 register write");
        run(1, 0, 1, 22'd0, 2, 13'd0);
        check_read(0, 1, 0, 2, "R10 memory untouched");

        // R1 chip select falling with clock high starts nothing
        step(1);
        bus_ck = 1'b1;
        step(2);
        bus_csn = 1'b0;
        step(2);
        for (int e = 0; e < 7; e++) begin
            dq_in = 8'hFF;
            step(1);
            bus_ck = ~bus_ck;
            step(HALF - 1);
            chk(rwds_oe === 1'b0 && dq_oe === 1'b0, "R1 no start with clock high",
                {rwds_oe, dq_oe}, 0);
        end
        bus_csn = 1'b1;
        step(2);
        bus_ck = 1'b0;
        step(2);
        run(1, 0, 1, 22'd20, 4, 13'd0);
        check_read(0, 1, 20, 4, "R1 next start");

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule